// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block generates eight edge-aligned PWM outputs from one free-running counter that all channels share. The counter advances on strobes from one of three clock sources: system, fixed-frequency or external. A power-of-two prescaler sits between the selected source and the counter. After each wrap the counter restarts from a programmable start value. Each channel compares the shared count against its own compare value. It also has a mask bit that forces the pin to its inactive level and a polarity bit that inverts the pin.

Software configures the timer through a flat register port: a write strobe, an address and write data, with combinational read data. A protection flag blocks writes to the timing configuration. Software clears the flag through a separate mode register and sets it again through the status register. Changes to period, prescaler and compare values are staged and take effect together at the next counter wrap. A running waveform therefore never shows a cut-short period.

Top module: `shared_pwm_timer`

## Requirements
- R1: All channels share one counter and one period of (modulo+1) counter ticks. With polarity 0 and no mask, channel n is high for min(compare_n, modulo+1) ticks of each period: high from the restart, low once the count reaches compare_n. A compare value of modulo+1 or more therefore holds the pin high for the whole period.
- R2: The prescaler field, CTRL bits [4:2] (0..7), makes the counter advance once every 2^value strobes of the selected source.
- R3: The clock select field, CTRL bits [1:0], encodes the source: 0 stops the counter, 1 selects tick_sys_i, 2 selects tick_fix_i and 3 selects tick_ext_i. Strobes on the sources that are not selected have no effect on the counter.
- R4: Register address 2 holds the start count, which resets to 0. After the count equals the modulo value on a tick, it reloads from the start count. While the counter is stopped it is held at the start count.
- R5: The mask register at address 3 resets to 0xFF. A 1 in bit n forces pwm_o[n] to its inactive level, which is the value of polarity bit n.
- R6: Bit n of the polarity register at address 4 inverts pwm_o[n].
- R7: The protection flag, status bit 0 at address 5, resets to 1. While it is set, writes to CTRL (0), modulo (1), start count (2), polarity (4), output-init (7) and compare (8+n) are ignored. Mask writes still apply. Every register reads back its current contents.
- R8: Writing 1 to bit 0 of the mode register at address 6 clears the protection flag. Writing 1 to status bit 0 sets it. Writing 0 to either bit changes nothing. The mode register reads as 0.
- R9: New modulo, prescaler and compare values take effect at the next counter wrap, so the period in progress finishes with its old length. While the counter is stopped, they take effect at once.
- R10: The output-init register at address 7 resets to 0. While the counter is stopped, each unmasked pin shows its output-init bit XOR its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_sys_i | input | 1 | System source count strobe |
| tick_fix_i | input | 1 | Fixed-frequency source count strobe |
| tick_ext_i | input | 1 | External source count strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| pwm_o | output | 8 | PWM outputs, bit n is channel n |

## Verification
The bench targets four behaviours.

- **Compare extremes.** It drives compare values of zero, exactly modulo+1, and far above the modulo. A design that compares with the wrong inequality would come up one tick short of a full period. A design that wraps the comparison would emit a glitch.
- **Source selection.** Unselected sources toggle at different rates the whole time. A mux that reads the wrong strobe shows a different period.
- **Staged period update.** The bench writes a new modulo in the middle of a period and measures the time between rising edges. A design that loads the value at once would cut the period in progress short.
- **Write protection.** The bench checks that mask writes still apply while the protection flag is set. It also checks that the mode register clears the flag and the status register sets it again. A design that protected the mask, or used a single toggle bit, would read back wrong values.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

  localparam int A_CTRL  = 0;
  localparam int A_MOD   = 1;
  localparam int A_START = 2;
  localparam int A_MASK  = 3;
  localparam int A_POL   = 4;
  localparam int A_STAT  = 5;
  localparam int A_MODE  = 6;
  localparam int A_OINIT = 7;
  localparam int A_CMP   = 8;
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
  import spwm_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [CNT_W-1:0]          wdata_i,
  output logic [CNT_W-1:0]          rdata_o,
  output src_e                      sel_o,
  output logic [PS_W-1:0]           ps_o,
  output logic [CNT_W-1:0]          mod_o,
  output logic [CNT_W-1:0]          start_o,
  output logic [NCH-1:0]            mask_o,
  output logic [NCH-1:0]            pol_o,
  output logic [NCH-1:0]            oinit_o,
  output logic [NCH-1:0][CNT_W-1:0] cmp_o,
  output logic                      wp_o
);
  logic open_w;
  assign open_w = we_i && !wp_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= SRC_OFF;
      ps_o    <= '0;
      mod_o   <= '1;
      start_o <= '0;
      mask_o  <= '1;
      pol_o   <= '0;
      oinit_o <= '0;
      cmp_o   <= '0;
      wp_o    <= 1'b1;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(A_MASK)) mask_o <= wdata_i[NCH-1:0];
      if (addr_i == ADDR_W'(A_STAT) && wdata_i[0]) wp_o <= 1'b1;
      if (addr_i == ADDR_W'(A_MODE) && wdata_i[0]) wp_o <= 1'b0;
      if (open_w) begin
        if (addr_i == ADDR_W'(A_CTRL)) begin
          sel_o <= src_e'(wdata_i[1:0]);
          ps_o  <= wdata_i[2 +: PS_W];
        end
        if (addr_i == ADDR_W'(A_MOD))   mod_o   <= wdata_i;
        if (addr_i == ADDR_W'(A_START)) start_o <= wdata_i;
        if (addr_i == ADDR_W'(A_POL))   pol_o   <= wdata_i[NCH-1:0];
        if (addr_i == ADDR_W'(A_OINIT)) oinit_o <= wdata_i[NCH-1:0];
        for (int i = 0; i < NCH; i++) begin
          if (addr_i == ADDR_W'(A_CMP + i)) cmp_o[i] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (int'(addr_i))
      A_CTRL:  rdata_o = CNT_W'({ps_o, sel_o});
      A_MOD:   rdata_o = mod_o;
      A_START: rdata_o = start_o;
      A_MASK:  rdata_o = CNT_W'(mask_o);
      A_POL:   rdata_o = CNT_W'(pol_o);
      A_STAT:  rdata_o = CNT_W'(wp_o);
      A_OINIT: rdata_o = CNT_W'(oinit_o);
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (addr_i == ADDR_W'(A_CMP + i)) rdata_o = cmp_o[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/spwm_timebase.sv
module spwm_timebase
  import spwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_e             sel_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             tick_sys_i,
  input  logic             tick_fix_i,
  input  logic             tick_ext_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             run_o
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [PRE_W:0]   lim_w;
  logic [PS_W-1:0]  ps_act;
  logic [CNT_W-1:0] mod_act;
  logic             src_tick, cnt_tick, wrap;

  always_comb begin
    unique case (sel_i)
      SRC_SYS: src_tick = tick_sys_i;
      SRC_FIX: src_tick = tick_fix_i;
      SRC_EXT: src_tick = tick_ext_i;
      default: src_tick = 1'b0;
    endcase
  end

  assign run_o    = (sel_i != SRC_OFF);
  assign lim_w    = ({{PRE_W{1'b0}}, 1'b1} << ps_act) - 1'b1;
  assign pre_lim  = lim_w[PRE_W-1:0];
  assign cnt_tick = src_tick && (pre_q == pre_lim);
  assign wrap     = cnt_tick && (cnt_o == mod_act);
  // stopped counter keeps the staging transparent
  assign load_o   = !run_o || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      cnt_o   <= '0;
      ps_act  <= '0;
      mod_act <= '1;
    end else begin
      if (load_o) begin
        ps_act  <= ps_i;
        mod_act <= mod_i;
      end
      if (!run_o) begin
        pre_q <= '0;
        cnt_o <= start_i;
      end else if (src_tick) begin
        pre_q <= cnt_tick ? '0 : pre_q + 1'b1;
        if (cnt_tick) cnt_o <= wrap ? start_i : cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spwm_chan.sv
module spwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             mask_i,
  input  logic             pol_i,
  input  logic             oinit_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_act;
  logic             raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_act <= '0;
    else if (load_i) cmp_act <= cmp_i;
  end

  assign raw   = run_i ? (cnt_i < cmp_act) : oinit_i;
  assign pwm_o = mask_i ? pol_i : (raw ^ pol_i);
endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
  import spwm_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CNT_W = 16,
  parameter int PS_W  = 3,
  localparam int ADDR_W = $clog2(A_CMP + NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_sys_i,
  input  logic              tick_fix_i,
  input  logic              tick_ext_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  src_e                      sel_q;
  logic [PS_W-1:0]           ps_q;
  logic [CNT_W-1:0]          mod_q, start_q, cnt_q;
  logic [NCH-1:0]            mask_q, pol_q, oinit_q;
  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  logic                      wp_q, load, run;

  spwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .sel_o(sel_q), .ps_o(ps_q), .mod_o(mod_q), .start_o(start_q),
    .mask_o(mask_q), .pol_o(pol_q), .oinit_o(oinit_q), .cmp_o(cmp_q),
    .wp_o(wp_q)
  );

  spwm_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
    .clk_i, .rst_ni,
    .sel_i(sel_q), .ps_i(ps_q), .mod_i(mod_q), .start_i(start_q),
    .tick_sys_i, .tick_fix_i, .tick_ext_i,
    .cnt_o(cnt_q), .load_o(load), .run_o(run)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    spwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni,
      .load_i(load), .run_i(run), .cnt_i(cnt_q), .cmp_i(cmp_q[g]),
      .mask_i(mask_q[g]), .pol_i(pol_q[g]), .oinit_i(oinit_q[g]),
      .pwm_o(pwm_o[g])
    );
  end
endmodule

// File: rtl/shared_pwm_timer_chk.sv
module shared_pwm_timer_chk
  import spwm_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_sys_i,
  input logic              tick_fix_i,
  input logic              tick_ext_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [CNT_W-1:0]  reg_wdata_i,
  input logic [NCH-1:0]    pwm_o,
  input logic [NCH-1:0]    mask_q,
  input logic [NCH-1:0]    pol_q,
  input logic [CNT_W-1:0]  mod_q,
  input logic [CNT_W-1:0]  start_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [1:0]        sel_q,
  input logic              wp_q
);
  logic sel_tick;
  assign sel_tick = (sel_q == 2'd1) ? tick_sys_i :
                    (sel_q == 2'd2) ? tick_fix_i :
                    (sel_q == 2'd3) ? tick_ext_i : 1'b0;

  // R5
  mask_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_o ^ pol_q) & mask_q) == '0);

  // R7
  wp_blocks_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_q && reg_we_i && reg_addr_i == ADDR_W'(A_MOD)) |=> $stable(mod_q));

  // R8
  wp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(A_MODE) && reg_wdata_i[0]) |=> !wp_q);

  // R8
  wp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(A_STAT) && reg_wdata_i[0]) |=> wp_q);

  // R4
  stop_hold_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == 2'd0) |=> (cnt_q == $past(start_q)));

  // R3
  unselected_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != 2'd0 && !sel_tick) |=> $stable(cnt_q));
endmodule

bind shared_pwm_timer shared_pwm_timer_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .tick_sys_i, .tick_fix_i, .tick_ext_i,
  .reg_we_i, .reg_addr_i, .reg_wdata_i, .pwm_o,
  .mask_q, .pol_q, .mod_q, .start_q, .cnt_q, .sel_q(sel_q), .wp_q
);

// File: tb/shared_pwm_timer_tb.sv
module shared_pwm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 200000;

  logic        clk_i = 0, rst_ni = 0;
  logic        tick_sys_i = 1, tick_fix_i = 0, tick_ext_i = 0;
  logic        reg_we_i = 0;
  logic [3:0]  reg_addr_i = 0;
  logic [15:0] reg_wdata_i = 0;
  logic [15:0] reg_rdata_o;
  logic [7:0]  pwm_o;

  int checks = 0, fails = 0;
  bit done = 0;

  shared_pwm_timer u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // fix strobe every 3 cycles, ext strobe every 2 cycles
  initial begin
    for (int k = 0; ; k++) begin
      @(negedge clk_i);
      tick_fix_i = (k % 3 == 0);
      tick_ext_i = (k % 2 == 0);
    end
  end

  // {ch, cmp, pol, ps}; modulo is 9
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'd3,   8'd0, 8'd0},
    {8'd1, 8'd0,   8'd0, 8'd0},
    {8'd2, 8'd10,  8'd0, 8'd0},
    {8'd3, 8'd200, 8'd0, 8'd0},
    {8'd4, 8'd5,   8'd1, 8'd0},
    {8'd5, 8'd7,   8'd0, 8'd1},
    {8'd6, 8'd1,   8'd0, 8'd3},
    {8'd7, 8'd9,   8'd1, 8'd2}
  };

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = 4'(a); reg_wdata_i = 16'(d);
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk_i);
    reg_addr_i = 4'(a);
    #1 d = int'(reg_rdata_o);
  endtask

  task automatic count_high(int ch, int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk_i);
      #1 if (pwm_o[ch]) c++;
    end
  endtask

  task automatic wait_rise(int ch);
    logic prev = 1;
    forever begin
      @(negedge clk_i);
      #1 if (!prev && pwm_o[ch]) break;
      prev = pwm_o[ch];
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WDOG);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int d, c, per, hi, gap;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1 check("R5 reset outputs", int'(pwm_o), 0);
    rd(3, d); check("R5 mask reset", d, 8'hFF);
    rd(5, d); check("R7 protect reset", d, 1);
    rd(7, d); check("R10 outinit reset", d, 0);
    rd(2, d); check("R4 start reset", d, 0);

    wr(1, 9); rd(1, d); check("R7 mod write blocked", d, 16'hFFFF);
    wr(3, 8'hFE); rd(3, d); check("R7 mask writable", d, 8'hFE);
    wr(6, 0); rd(5, d); check("R8 mode zero no effect", d, 1);
    wr(6, 1); rd(5, d); check("R8 mode clears", d, 0);
    rd(6, d); check("R8 mode reads zero", d, 0);

    wr(3, 0);
    #1 check("R10 stopped oinit 0", int'(pwm_o), 0);
    wr(7, 1);
    #1 check("R10 stopped oinit 1", int'(pwm_o[0]), 1);
    wr(4, 1);
    #1 check("R10 stopped oinit xor pol", int'(pwm_o[0]), 0);
    wr(4, 0); wr(7, 0);

    wr(1, 9);
    wr(0, 1);
    foreach (VEC[i]) begin
      automatic int ch = VEC[i][31:24];
      automatic int cv = VEC[i][23:16];
      automatic int pl = VEC[i][15:8];
      automatic int ps = VEC[i][7:0];
      wr(8 + ch, cv);
      wr(4, pl << ch);
      wr(0, (ps << 2) | 1);
      repeat (200) @(negedge clk_i);
      per = 10 << ps;
      hi  = ((cv > 10) ? 10 : cv) << ps;
      if (pl != 0) hi = per - hi;
      count_high(ch, per, c);
      check((ps != 0) ? "R2 prescaled duty" : ((pl != 0) ? "R6 inverted duty" : "R1 duty"), c, hi);
    end

    // start count
    wr(0, 1); wr(4, 0); wr(8, 7); wr(2, 5);
    repeat (50) @(negedge clk_i);
    count_high(0, 5, c); check("R4 start count duty", c, 2);
    wr(2, 0); wr(8, 3);
    repeat (50) @(negedge clk_i);

    // mask drives inactive level
    wr(4, 1); wr(3, 1);
    count_high(0, 10, c); check("R5 mask with pol", c, 10);
    wr(4, 0);
    count_high(0, 10, c); check("R5 mask no pol", c, 0);
    wr(3, 0);

    // clock source selection
    wr(0, 2);
    repeat (100) @(negedge clk_i);
    count_high(0, 30, c); check("R3 fix source duty", c, 9);
    wr(0, 3);
    repeat (100) @(negedge clk_i);
    count_high(0, 20, c); check("R3 ext source duty", c, 6);

    wr(0, 0); wr(7, 1);
    count_high(0, 10, c); check("R10 stopped high", c, 10);
    wr(7, 0);
    count_high(0, 10, c); check("R10 stopped low", c, 0);

    // staged modulo update
    wr(0, 1);
    repeat (50) @(negedge clk_i);
    wait_rise(0);
    reg_we_i = 1; reg_addr_i = 4'd1; reg_wdata_i = 16'd99;
    begin
      logic prev = 1;
      gap = 0;
      forever begin
        @(negedge clk_i);
        reg_we_i = 0;
        #1 gap++;
        if (!prev && pwm_o[0]) break;
        prev = pwm_o[0];
      end
    end
    check("R9 old period completes", gap, 10);
    begin
      logic prev = 1;
      gap = 0;
      forever begin
        @(negedge clk_i);
        #1 gap++;
        if (!prev && pwm_o[0]) break;
        prev = pwm_o[0];
      end
    end
    check("R9 new period", gap, 100);

    // protection set again
    wr(5, 1); rd(5, d); check("R8 status sets", d, 1);
    wr(4, 8'hFF); rd(4, d); check("R7 pol blocked", d, 0);
    wr(8, 50); rd(8, d); check("R7 cmp blocked readback", d, 3);

    finish_run();
  end
endmodule